// File: doc/BRIEF.md
# Wavetable Memory DMA Engine

This block moves a run of bytes between a host byte stream and a wavetable memory with a 20-bit byte address. Software sets up a 16-bit paragraph start register and an 8-bit byte-offset extension register, supplies a transfer count, and writes an 8-bit control register whose request bit starts the move. The control register also selects the direction, the treatment of the sample sign bit and the terminal-count interrupt. An input that marks the channel as 16-bit makes every count unit two bytes and remaps the memory address.

Upload (host to wavetable) takes bytes from a valid/ready input stream and writes them to memory. Download (wavetable to host) reads memory and offers the bytes on a valid/ready output stream. The memory read is combinational. When the last byte has moved, the engine advances the start and extension registers past the block, drops the request bit, pulses `done` and, if enabled, raises `irq`. Reading the control register reports the pending interrupt and clears it.

Top module: `wt_dma_engine`

## Requirements
- R1: On an 8-bit channel, the first byte goes to address base = (start << 4) + ext[3:0], truncated to 20 bits. Each following byte goes to the next address.
- R2: On a 16-bit channel (`wide_chan`=1), a count of N moves 2N bytes. The first byte goes to (base & 0xC0000) + 2*(base & 0x1FFF0), and each following byte to the next address.
- R3: Control bit 1 = 0 selects upload: a byte moves in each cycle with `h2w_valid` and `h2w_ready` both high, writing `mem_wdata` at `mem_addr`. Bit 1 = 1 selects download: a byte moves in each cycle with `w2h_valid` and `w2h_ready` both high, and `w2h_data` is taken from `mem_rdata`. No write occurs in a cycle without a beat.
- R4: Bit 7 of a byte is inverted only on upload with control bit 7 set. It is inverted on every byte unless control bit 6 is set. When bit 6 is set, only the odd (high) bytes of a 16-bit channel are inverted. Download data is never altered.
- R5: After a transfer of count N, start becomes start + (N >> 4) modulo 2^16, and ext becomes (N + ext) & 0xF.
- R6: In the cycle after the last byte, `done` is high for one cycle and control bit 0 reads 0. `irq` is then high exactly when control bit 5 was set.
- R7: `ctrl_rdata` shows the stored control bits, except that bit 6 shows the pending interrupt and bit 2 shows `wide_chan`. A cycle with `ctrl_rd` high clears the pending interrupt. If a completion falls in that same cycle, the interrupt is set.
- R8: A write to the start register clears ext[7:4]. A write to the extension register stores all 8 bits.
- R9: While a transfer is in progress, writes to the control, start and extension registers have no effect.
- R10: After reset, the control, start and extension registers read 0, `irq` and `done` are 0, and neither stream side is active.
- R11: A count of 0 completes without any beat, with the same register advance, `done` and `irq` behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_chan | input | 1 | Channel is 16-bit |
| cfg_wr_ctrl | input | 1 | Write control register from cfg_wdata[7:0] |
| cfg_wr_start | input | 1 | Write start register from cfg_wdata |
| cfg_wr_ext | input | 1 | Write extension register from cfg_wdata[7:0] |
| cfg_wdata | input | 16 | Configuration write data |
| xfer_len | input | LEN_W | Transfer count, sampled when the request starts |
| ctrl_rd | input | 1 | Control register read strobe (clears pending interrupt) |
| ctrl_rdata | output | 8 | Control register read value |
| start_reg | output | 16 | Current start register |
| ext_reg | output | 8 | Current extension register |
| h2w_valid | input | 1 | Host byte available (upload) |
| h2w_data | input | 8 | Host byte |
| h2w_ready | output | 1 | Engine accepts host byte |
| w2h_valid | output | 1 | Engine offers byte to host (download) |
| w2h_data | output | 8 | Byte to host |
| w2h_ready | input | 1 | Host accepts byte |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 20 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle |
| irq | output | 1 | Terminal-count interrupt pending |
| done | output | 1 | One-cycle completion pulse |

## Verification
A control-register read can land in the same cycle as the final beat. In that cycle the read-clear and the terminal-count set compete for the interrupt bit. The bench provokes this by raising `ctrl_rd` together with the last stream beat in several runs. It then requires that the value read in that cycle still shows no pending interrupt, and that `irq` is high in the following cycle. A later plain read must clear it. Configuration writes during a stalled stream cycle are also checked to leave the final start and extension values unchanged.

// File: rtl/wt_dma_pkg.sv
package wt_dma_pkg;
    localparam int ADDR_W  = 20;
    localparam int START_W = 16;
    localparam int EXT_W   = 8;
    localparam int BYTE_W  = 8;

    typedef struct packed {
        logic       inv_msb;   // bit 7: flip sample sign on upload
        logic       lo_pass;   // bit 6: 16-bit data, low byte untouched
        logic       tc_ien;    // bit 5: interrupt at terminal count
        logic [2:0] spare;     // bits 4..2
        logic       to_host;   // bit 1: direction
        logic       req;       // bit 0: request / running
    } ctrl_t;

    function automatic logic [ADDR_W-1:0] base_addr(input logic [START_W-1:0] st,
                                                    input logic [EXT_W-1:0] ex);
        return ADDR_W'({st, 4'b0000}) + ADDR_W'(ex[3:0]);
    endfunction

    function automatic logic [ADDR_W-1:0] xlate_wide(input logic [ADDR_W-1:0] a);
        return (a & 20'hC0000) + ((a & 20'h1FFF0) << 1);
    endfunction

    function automatic logic [BYTE_W-1:0] sign_mask(input logic inv, input logic lo_pass,
                                                     input logic hi_phase);
        return (inv && (hi_phase || !lo_pass)) ? 8'h80 : 8'h00;
    endfunction
endpackage

// File: rtl/wt_dma_regs.sv
module wt_dma_regs
    import wt_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wide_chan,
    input  logic                 cfg_wr_ctrl,
    input  logic                 cfg_wr_start,
    input  logic                 cfg_wr_ext,
    input  logic [15:0]          cfg_wdata,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic                 ctrl_rd,
    input  logic                 finish,
    output ctrl_t                ctrl_q,
    output logic                 go,
    output logic [START_W-1:0]   start_q,
    output logic [EXT_W-1:0]     ext_q,
    output logic                 tc_pend,
    output logic                 done_q,
    output logic [7:0]           rdata
);
    logic [LEN_W-1:0] len_q;
    logic             lock;

    assign lock = ctrl_q.req;
    assign go   = cfg_wr_ctrl && !lock && cfg_wdata[0];

    always_comb begin
        rdata    = ctrl_q;
        rdata[6] = tc_pend;
        rdata[2] = wide_chan;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= '0;
            ext_q   <= '0;
            len_q   <= '0;
            tc_pend <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (!lock) begin
                if (cfg_wr_ctrl) ctrl_q <= ctrl_t'(cfg_wdata[7:0]);
                if (go) len_q <= xfer_len;
                if (cfg_wr_ext) ext_q <= cfg_wdata[EXT_W-1:0];
                if (cfg_wr_start) begin
                    start_q    <= cfg_wdata[START_W-1:0];
                    ext_q[7:4] <= 4'h0;
                end
            end
            if (finish) begin
                ctrl_q.req <= 1'b0;
                start_q    <= start_q + START_W'(len_q >> 4);
                ext_q      <= {4'h0, 4'(len_q[3:0] + ext_q[3:0])};
            end
            if (finish && ctrl_q.tc_ien) tc_pend <= 1'b1;
            else if (ctrl_rd)            tc_pend <= 1'b0;
        end
    end

    p_done_clears_req_r6: assert property (@(posedge clk) disable iff (rst)
        finish |=> !ctrl_q.req && done_q);
    p_tc_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (finish && ctrl_q.tc_ien) |=> tc_pend);
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (lock && !finish) |=> $stable(start_q) && $stable(ext_q));
endmodule

// File: rtl/wt_dma_mover.sv
module wt_dma_mover
    import wt_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [ADDR_W-1:0]    first_addr,
    input  logic [LEN_W-1:0]     xfer_len,
    input  logic                 wide_chan,
    input  ctrl_t                ctrl,
    input  logic                 h2w_valid,
    input  logic [BYTE_W-1:0]    h2w_data,
    output logic                 h2w_ready,
    output logic                 w2h_valid,
    output logic [BYTE_W-1:0]    w2h_data,
    input  logic                 w2h_ready,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [BYTE_W-1:0]    mem_wdata,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic                 finish
);
    localparam int CNT_W = LEN_W + 1;

    logic              busy_q;
    logic              phase_q;
    logic [CNT_W-1:0]  left_q;
    logic [ADDR_W-1:0] addr_q;
    logic              have;
    logic              beat;

    assign have      = busy_q && (left_q != '0);
    assign h2w_ready = have && !ctrl.to_host;
    assign w2h_valid = have && ctrl.to_host;
    assign beat      = ctrl.to_host ? (w2h_valid && w2h_ready) : (h2w_valid && h2w_ready);
    assign mem_we    = h2w_valid && h2w_ready;
    assign mem_re    = w2h_valid;
    assign mem_addr  = addr_q;
    assign mem_wdata = h2w_data ^ sign_mask(ctrl.inv_msb, ctrl.lo_pass, wide_chan && phase_q);
    assign w2h_data  = mem_rdata;
    assign finish    = busy_q && ((left_q == CNT_W'(1) && beat) || left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            left_q  <= '0;
            addr_q  <= '0;
        end else if (go) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            left_q  <= wide_chan ? {xfer_len, 1'b0} : {1'b0, xfer_len};
            addr_q  <= wide_chan ? xlate_wide(first_addr) : first_addr;
        end else begin
            if (finish) busy_q <= 1'b0;
            if (beat) begin
                addr_q  <= addr_q + ADDR_W'(1);
                left_q  <= left_q - CNT_W'(1);
                phase_q <= !phase_q;
            end
        end
    end

    p_one_dir_r3: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_q |-> (!h2w_ready && !w2h_valid));
    p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(beat) && busy_q) |-> addr_q == ADDR_W'($past(addr_q) + ADDR_W'(1)));
endmodule

// File: rtl/wt_dma_engine.sv
module wt_dma_engine
    import wt_dma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_chan,
    input  logic              cfg_wr_ctrl,
    input  logic              cfg_wr_start,
    input  logic              cfg_wr_ext,
    input  logic [15:0]       cfg_wdata,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              ctrl_rd,
    output logic [7:0]        ctrl_rdata,
    output logic [15:0]       start_reg,
    output logic [7:0]        ext_reg,
    input  logic              h2w_valid,
    input  logic [7:0]        h2w_data,
    output logic              h2w_ready,
    output logic              w2h_valid,
    output logic [7:0]        w2h_data,
    input  logic              w2h_ready,
    output logic              mem_we,
    output logic              mem_re,
    output logic [19:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              irq,
    output logic              done
);
    ctrl_t             ctrl_q;
    logic              go;
    logic              finish;
    logic [ADDR_W-1:0] first_addr;

    assign first_addr = base_addr(start_reg, ext_reg);

    wt_dma_regs #(.LEN_W(LEN_W)) regs_i (
        .clk(clk), .rst(rst), .wide_chan(wide_chan),
        .cfg_wr_ctrl(cfg_wr_ctrl), .cfg_wr_start(cfg_wr_start), .cfg_wr_ext(cfg_wr_ext),
        .cfg_wdata(cfg_wdata), .xfer_len(xfer_len), .ctrl_rd(ctrl_rd), .finish(finish),
        .ctrl_q(ctrl_q), .go(go), .start_q(start_reg), .ext_q(ext_reg),
        .tc_pend(irq), .done_q(done), .rdata(ctrl_rdata)
    );

    wt_dma_mover #(.LEN_W(LEN_W)) mover_i (
        .clk(clk), .rst(rst), .go(go), .first_addr(first_addr), .xfer_len(xfer_len),
        .wide_chan(wide_chan), .ctrl(ctrl_q),
        .h2w_valid(h2w_valid), .h2w_data(h2w_data), .h2w_ready(h2w_ready),
        .w2h_valid(w2h_valid), .w2h_data(w2h_data), .w2h_ready(w2h_ready),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .finish(finish)
    );
endmodule

// File: tb/wt_dma_engine_tb_top.sv
module wt_dma_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide_chan = 1'b0;
    logic        cfg_wr_ctrl = 1'b0, cfg_wr_start = 1'b0, cfg_wr_ext = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] xfer_len = '0;
    logic        ctrl_rd = 1'b0;
    logic [7:0]  ctrl_rdata;
    logic [15:0] start_reg;
    logic [7:0]  ext_reg;
    logic        h2w_valid = 1'b0;
    logic [7:0]  h2w_data = '0;
    logic        h2w_ready, w2h_valid, w2h_ready_unused;
    logic [7:0]  w2h_data;
    logic        w2h_ready = 1'b0;
    logic        mem_we, mem_re;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        irq, done;

    int checks = 0;
    int errors = 0;

    assign w2h_ready_unused = 1'b0;
    assign mem_rdata = mem_addr[7:0] ^ mem_addr[19:12] ^ 8'h5A;

    always #10 clk = ~clk;

    wt_dma_engine dut_i (
        .clk(clk), .rst(rst), .wide_chan(wide_chan),
        .cfg_wr_ctrl(cfg_wr_ctrl), .cfg_wr_start(cfg_wr_start), .cfg_wr_ext(cfg_wr_ext),
        .cfg_wdata(cfg_wdata), .xfer_len(xfer_len), .ctrl_rd(ctrl_rd),
        .ctrl_rdata(ctrl_rdata), .start_reg(start_reg), .ext_reg(ext_reg),
        .h2w_valid(h2w_valid), .h2w_data(h2w_data), .h2w_ready(h2w_ready),
        .w2h_valid(w2h_valid), .w2h_data(w2h_data), .w2h_ready(w2h_ready),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i, input int n);
        return 8'((i * 29) + (n * 7) + 3);
    endfunction

    task automatic run(input bit wide, input bit dir, input bit inv, input bit lop,
                       input bit ien, input bit gap, input bit rd_last,
                       input logic [15:0] st, input logic [7:0] ex, input int n);
        int total = wide ? 2 * n : n;
        logic [19:0] base;
        logic [15:0] exp_st;
        logic [7:0]  exp_ex;
        int i = 0;
        int cyc = 0;
        base = 20'({st, 4'b0}) + 20'(ex[3:0]);
        if (wide) base = (base & 20'hC0000) + ((base & 20'h1FFF0) << 1);
        exp_st = st + 16'(n >> 4);
        exp_ex = {4'h0, 4'(n + int'(ex))};
        wide_chan = wide;
        cfg_wr_start = 1'b1; cfg_wdata = st; tick();
        cfg_wr_start = 1'b0; cfg_wr_ext = 1'b1; cfg_wdata = {8'h00, ex}; tick();
        cfg_wr_ext = 1'b0; xfer_len = 16'(n);
        cfg_wr_ctrl = 1'b1; cfg_wdata = {8'h00, inv, lop, ien, 3'b000, dir, 1'b1}; tick();
        cfg_wr_ctrl = 1'b0;
        while (i < total) begin
            bit act = !gap || (cyc % 2 == 0);
            bit last = (i == total - 1);
            logic [7:0] expd;
            cfg_wr_start = 1'b0; cfg_wr_ext = 1'b0; cfg_wr_ctrl = 1'b0;
            if (gap && cyc == 1) begin
                // R9: configuration writes during a transfer must be ignored
                cfg_wr_start = 1'b1; cfg_wr_ext = 1'b1; cfg_wr_ctrl = 1'b1;
                cfg_wdata = 16'hFFFF;
            end
            h2w_valid = !dir && act;
            w2h_ready = dir && act;
            h2w_data  = pat(i, n);
            ctrl_rd   = rd_last && act && last;
            #2;
            if (act) begin
                check(mem_addr == 20'(base + 20'(i)), wide ? "R2 address" : "R1 address",
                      32'(mem_addr), 32'(base + 20'(i)));
                if (!dir) begin
                    expd = pat(i, n) ^ (((inv && ((wide && i % 2 == 1) || !lop))) ? 8'h80 : 8'h00);
                    check(mem_we == 1'b1, "R3 upload write strobe", 32'(mem_we), 32'd1);
                    check(mem_wdata == expd, "R4 upload data", 32'(mem_wdata), 32'(expd));
                end else begin
                    check(w2h_valid == 1'b1, "R3 download valid", 32'(w2h_valid), 32'd1);
                    check(w2h_data == mem_rdata, "R4 download data untouched",
                          32'(w2h_data), 32'(mem_rdata));
                end
                if (rd_last && last)
                    check(ctrl_rdata[6] == 1'b0, "R7 read in completion cycle",
                          32'(ctrl_rdata[6]), 32'd0);
            end else begin
                check(mem_we == 1'b0, "R3 no write without beat", 32'(mem_we), 32'd0);
            end
            tick();
            if (act) i++;
            cyc++;
        end
        h2w_valid = 1'b0; w2h_ready = 1'b0; ctrl_rd = 1'b0;
        cfg_wr_start = 1'b0; cfg_wr_ext = 1'b0; cfg_wr_ctrl = 1'b0;
        if (total == 0) begin
            #2;
            check(!h2w_ready && !w2h_valid && !mem_we, "R11 zero count no beat",
                  32'({h2w_ready, w2h_valid, mem_we}), 32'd0);
            tick();
        end
        #2;
        check(done == 1'b1, "R6 done pulse", 32'(done), 32'd1);
        check(irq == ien, "R6 irq after completion", 32'(irq), 32'(ien));
        check(ctrl_rdata[0] == 1'b0, "R6 request cleared", 32'(ctrl_rdata[0]), 32'd0);
        check(start_reg == exp_st, "R5 start advance", 32'(start_reg), 32'(exp_st));
        check(ext_reg == exp_ex, "R5 ext advance", 32'(ext_reg), 32'(exp_ex));
        if (gap)
            check(start_reg == exp_st && ext_reg == exp_ex, "R9 writes ignored while busy",
                  32'({start_reg, ext_reg}), 32'({exp_st, exp_ex}));
        tick();
        #2;
        check(done == 1'b0, "R6 done one cycle", 32'(done), 32'd0);
        ctrl_rd = 1'b1;
        #1;
        check(ctrl_rdata == {inv, ien, ien, 2'b00, wide, dir, 1'b0}, "R7 control read value",
              32'(ctrl_rdata), 32'({inv, ien, ien, 2'b00, wide, dir, 1'b0}));
        tick();
        ctrl_rd = 1'b0;
        #2;
        check(irq == 1'b0 && ctrl_rdata[6] == 1'b0, "R7 read clears pending",
              32'({irq, ctrl_rdata[6]}), 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        // R10: reset state
        check(ctrl_rdata == 8'h00 && start_reg == 16'h0 && ext_reg == 8'h0,
              "R10 registers after reset", 32'({ctrl_rdata, start_reg, ext_reg}), 32'd0);
        check(!irq && !done && !h2w_ready && !w2h_valid, "R10 outputs after reset",
              32'({irq, done, h2w_ready, w2h_valid}), 32'd0);
        tick();
        // R8: start write clears upper ext nibble
        cfg_wr_ext = 1'b1; cfg_wdata = 16'h00A5; tick();
        cfg_wr_ext = 1'b0; #2;
        check(ext_reg == 8'hA5, "R8 ext full write", 32'(ext_reg), 32'hA5);
        cfg_wr_start = 1'b1; cfg_wdata = 16'h1234; tick();
        cfg_wr_start = 1'b0; #2;
        check(ext_reg == 8'h05 && start_reg == 16'h1234, "R8 start write clears ext[7:4]",
              32'({start_reg, ext_reg}), 32'h123405);
        tick();
        // Sweep of mode combinations
        for (int m = 0; m < 16; m++) begin
            bit wide = m[0];
            bit dir  = m[1];
            bit inv  = m[2];
            bit lop  = m[3];
            run(wide, dir, inv, lop, inv | wide, lop ^ dir, m[0] ^ m[2],
                16'(m * 16'h1111 + 16'h0103), 8'(m * 37 + 11), 3 + m * 2);
        end
        // Boundary counts and wrap cases
        run(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, 8'h0F, 17);
        run(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'hFFFE, 8'h3C, 33);
        run(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h4000, 8'h07, 16);
        run(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'hC7F0, 8'h09, 1);
        // R11: zero count
        run(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0020, 8'h0B, 0);
        run(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0021, 8'h03, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule